// File: doc/BRIEF.md
# Host Mailbox Register Interface

This block sits between a host processor bus and a small local controller core. The host sees three byte-wide registers. It writes commands and data into an input register. It reads results from an output register. It polls an 8-bit status register that reports whether each register holds unread data, plus four status bits the core defines. Every host write records its address bit in a status flag, so the core can tell a command byte from a data byte. The core has strobes to take the input byte, post an output byte, set the upper status nibble and set its own flag.

Four upper port lines can each keep their plain latch value or take on a handshake role. Two of them can signal "output ready" and "input free" to an interrupt controller. The other two can carry a DMA request and receive a DMA acknowledge, which then selects the data registers in place of chip select. Host strobes take effect on their trailing edge. A host read of the status register freezes that register, and any core update made meanwhile is held until the read ends.

Top module: `hostlink_buffer`

## Requirements
- R1: After reset, status bits (7:4 user, 3 command flag, 2 core flag, 1 input-full, 0 output-full) are all 0. The upper-port outputs are 4'hF, all in plain latch mode. The host bus is not driven.
- R2: A host write with host_a0=0 stores host_din in the input register, sets input-full (bit 1) and clears the command flag (bit 3).
- R3: A host write with host_a0=1 stores the byte, sets input-full and sets the command flag.
- R4: Host strobes act on their trailing edge. While host_wr_n is still low, input-full and the command flag keep their previous values.
- R5: core_sts_wr copies core_wdata[7:4] into status bits 7:4 and leaves bits 3:0 unchanged.
- R6: While a host status read is in progress (from the first clock with the read sampled active), the status register does not change. A user-nibble write or input-register read by the core during that time takes effect after the read ends.
- R7: core_in_rd clears input-full. core_out_wr loads the output register and sets output-full. The end of a host read with host_a0=0 clears output-full.
- R8: A selected host read returns the status register when host_a0=1 and the output register when host_a0=0. host_doe is high only in the clock after each clock in which the read is sampled active.
- R9: The upper-port latch (port_hi_out bits 3:0) is loaded from core_wdata[7:4] by core_port_wr. After core_en_flags, bit 0 shows output-full ANDed with latch bit 0, and bit 1 shows NOT input-full ANDed with latch bit 1.
- R10: After core_en_dma, a port write with core_wdata[6]=1 raises the request on port_hi_out[2]. It is cleared by the end of a host read or write made with dack_n low, or by another core_en_dma.
- R11: After core_en_dma, dack_n low selects the data registers without chip select, whatever host_a0 is, and port_hi_out[3] stays 1. Before core_en_dma, dack_n has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address bit: 1 command/status, 0 data |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Host bus output enable |
| dack_n | input | 1 | DMA acknowledge pin, active low |
| core_in_rd | input | 1 | Core takes the input register |
| core_in_data | output | 8 | Input register contents |
| core_out_wr | input | 1 | Core loads the output register |
| core_sts_wr | input | 1 | Core loads status bits 7:4 |
| core_f0_we | input | 1 | Core writes the core flag |
| core_f0_val | input | 1 | Value for the core flag |
| core_wdata | input | 8 | Core write data |
| core_port_wr | input | 1 | Core loads the upper-port latch |
| core_en_flags | input | 1 | Switch bits 0 and 1 to buffer-flag role |
| core_en_dma | input | 1 | Switch bits 2 and 3 to DMA role, clear request |
| core_flags | output | 4 | Status bits 3:0 for the core |
| port_hi_out | output | 4 | Upper port line values |

## Verification
Directed sequences cover the cases random traffic rarely reaches. One holds a write strobe low to show the flags wait for the trailing edge. Another lands core updates inside a status read to show they are deferred and not lost. A third compares acknowledge-driven access before and after DMA mode to show acknowledge is ignored and then acts as a select that overrides the address bit. Seeded random mixes of host reads and writes, core strobes and port writes then run against a bench model of the flags, registers and pin roles. Command and data writes interleave with core reads, so the command flag and input-full history is checked as well as single events.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  // status bit positions (the host decodes these)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_F0  = 2;
  localparam int ST_F1  = 3;
  localparam int ST_USR = 4;
  // upper-port line roles
  localparam int PIN_OBF  = 0;
  localparam int PIN_IBF  = 1;
  localparam int PIN_DRQ  = 2;
  localparam int PIN_DACK = 3;
  localparam int PIN_N    = 4;

  typedef struct packed {
    logic done;
    logic a0;
    logic dack;
  } host_evt_t;
endpackage

// File: rtl/hostlink_hostif.sv
module hostlink_hostif
  import hostlink_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic [DW-1:0] din,
  input  logic          dack_n,
  input  logic          dma_en,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] obuf,
  output host_evt_t     wr_evt,
  output host_evt_t     rd_evt,
  output logic [DW-1:0] wr_data,
  output logic          lock,
  output logic [DW-1:0] dout,
  output logic          doe
);
  logic sel_dack, sel, a0_eff, rd_act, wr_act;
  logic rd_q, wr_q, rd_a0_q, wr_a0_q, rd_dk_q, wr_dk_q;
  logic [DW-1:0] wdat_q;

  assign sel_dack = dma_en & ~dack_n;
  assign sel      = ~cs_n | sel_dack;
  assign a0_eff   = a0 & ~sel_dack;   // acknowledge always means data
  assign rd_act   = sel & ~rd_n;
  assign wr_act   = sel & ~wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      rd_a0_q <= 1'b0;
      wr_a0_q <= 1'b0;
      rd_dk_q <= 1'b0;
      wr_dk_q <= 1'b0;
      wdat_q  <= '0;
      dout    <= '0;
      doe     <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (rd_act) begin
        rd_a0_q <= a0_eff;
        rd_dk_q <= sel_dack;
      end
      if (wr_act) begin
        wr_a0_q <= a0_eff;
        wr_dk_q <= sel_dack;
        wdat_q  <= din;
      end
      doe  <= rd_act;
      dout <= rd_act ? (a0_eff ? status : obuf) : '0;
    end
  end

  assign wr_evt  = '{done: wr_q & ~wr_act, a0: wr_a0_q, dack: wr_dk_q};
  assign rd_evt  = '{done: rd_q & ~rd_act, a0: rd_a0_q, dack: rd_dk_q};
  assign wr_data = wdat_q;
  assign lock    = rd_q & rd_a0_q;
endmodule

// File: rtl/hostlink_status.sv
module hostlink_status
  import hostlink_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lock,
  input  host_evt_t      wr_evt,
  input  host_evt_t      rd_evt,
  input  logic           core_in_rd,
  input  logic           core_out_wr,
  input  logic           core_sts_wr,
  input  logic           core_f0_we,
  input  logic           core_f0_val,
  input  logic [DW-5:0]  core_nib,
  output logic [DW-1:0]  status
);
  localparam int UW = DW - ST_USR;

  logic [UW-1:0] usr_q, p_usr, usr_val;
  logic f1_q, f0_q, ibf_q, obf_q;
  logic p_usr_v, p_f0_v, p_f0, p_obf, p_ibfc;
  logic usr_req, f0_req, f0_val, obf_req, ibfc_req;

  // a fresh core request overrides one still waiting
  assign usr_req  = core_sts_wr | p_usr_v;
  assign usr_val  = core_sts_wr ? core_nib : p_usr;
  assign f0_req   = core_f0_we | p_f0_v;
  assign f0_val   = core_f0_we ? core_f0_val : p_f0;
  assign obf_req  = core_out_wr | p_obf;
  assign ibfc_req = core_in_rd | p_ibfc;

  always_ff @(posedge clk) begin
    if (rst) begin
      usr_q   <= '0;
      f1_q    <= 1'b0;
      f0_q    <= 1'b0;
      ibf_q   <= 1'b0;
      obf_q   <= 1'b0;
      p_usr_v <= 1'b0;
      p_usr   <= '0;
      p_f0_v  <= 1'b0;
      p_f0    <= 1'b0;
      p_obf   <= 1'b0;
      p_ibfc  <= 1'b0;
    end else begin
      if (lock) begin
        p_usr_v <= usr_req;
        p_usr   <= usr_val;
        p_f0_v  <= f0_req;
        p_f0    <= f0_val;
        p_obf   <= obf_req;
        p_ibfc  <= ibfc_req & ~wr_evt.done;
      end else begin
        p_usr_v <= 1'b0;
        p_f0_v  <= 1'b0;
        p_obf   <= 1'b0;
        p_ibfc  <= 1'b0;
        if (usr_req) usr_q <= usr_val;
        if (f0_req)  f0_q  <= f0_val;
      end
      // host write completion wins over a core take
      if (wr_evt.done) begin
        ibf_q <= 1'b1;
        f1_q  <= wr_evt.a0;
      end else if (ibfc_req && !lock) begin
        ibf_q <= 1'b0;
      end
      // a new core byte wins over a host data read
      if (obf_req && !lock)
        obf_q <= 1'b1;
      else if (rd_evt.done && !rd_evt.a0)
        obf_q <= 1'b0;
    end
  end

  always_comb begin
    status                   = '0;
    status[DW-1:ST_USR]      = usr_q;
    status[ST_F1]            = f1_q;
    status[ST_F0]            = f0_q;
    status[ST_IBF]           = ibf_q;
    status[ST_OBF]           = obf_q;
  end
endmodule

// File: rtl/hostlink_pins.sv
module hostlink_pins
  import hostlink_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_port_wr,
  input  logic [DW-1:0]    core_wdata,
  input  logic             core_en_flags,
  input  logic             core_en_dma,
  input  logic             obf,
  input  logic             ibf,
  input  host_evt_t        wr_evt,
  input  host_evt_t        rd_evt,
  output logic             dma_en,
  output logic             drq,
  output logic [PIN_N-1:0] pin_out
);
  localparam int PL = DW - PIN_N;

  logic [PIN_N-1:0] latch_q, pin_nx;
  logic flags_en_q, dack_end;

  assign dack_end = (wr_evt.done & wr_evt.dack) | (rd_evt.done & rd_evt.dack);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '1;
      flags_en_q <= 1'b0;
      dma_en     <= 1'b0;
      drq        <= 1'b0;
      pin_out    <= '1;
    end else begin
      if (core_port_wr)  latch_q    <= core_wdata[DW-1:PL];
      if (core_en_flags) flags_en_q <= 1'b1;
      if (core_en_dma)   dma_en     <= 1'b1;
      if (core_en_dma)
        drq <= 1'b0;
      else if (core_port_wr && dma_en && core_wdata[PL+PIN_DRQ])
        drq <= 1'b1;
      else if (dack_end)
        drq <= 1'b0;
      pin_out <= pin_nx;
    end
  end

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    if (i == PIN_OBF) begin : g_obf
      assign pin_nx[i] = latch_q[i] & (flags_en_q ? obf : 1'b1);
    end else if (i == PIN_IBF) begin : g_ibf
      assign pin_nx[i] = latch_q[i] & (flags_en_q ? ~ibf : 1'b1);
    end else if (i == PIN_DRQ) begin : g_drq
      assign pin_nx[i] = dma_en ? drq : latch_q[i];
    end else begin : g_dack
      assign pin_nx[i] = dma_en ? 1'b1 : latch_q[i];
    end
  end
endmodule

// File: rtl/hostlink_buffer.sv
module hostlink_buffer
  import hostlink_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_cs_n,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic             host_a0,
  input  logic [DW-1:0]    host_din,
  output logic [DW-1:0]    host_dout,
  output logic             host_doe,
  input  logic             dack_n,
  input  logic             core_in_rd,
  output logic [DW-1:0]    core_in_data,
  input  logic             core_out_wr,
  input  logic             core_sts_wr,
  input  logic             core_f0_we,
  input  logic             core_f0_val,
  input  logic [DW-1:0]    core_wdata,
  input  logic             core_port_wr,
  input  logic             core_en_flags,
  input  logic             core_en_dma,
  output logic [3:0]       core_flags,
  output logic [PIN_N-1:0] port_hi_out
);
  host_evt_t     wr_evt, rd_evt;
  logic [DW-1:0] wr_data, status, ibuf_q, obuf_q;
  logic          lock, dma_en, drq;

  hostlink_hostif #(.DW(DW)) u_hostif (
    .clk(clk), .rst(rst), .cs_n(host_cs_n), .rd_n(host_rd_n), .wr_n(host_wr_n),
    .a0(host_a0), .din(host_din), .dack_n(dack_n), .dma_en(dma_en),
    .status(status), .obuf(obuf_q), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .wr_data(wr_data), .lock(lock), .dout(host_dout), .doe(host_doe)
  );

  hostlink_status #(.DW(DW)) u_status (
    .clk(clk), .rst(rst), .lock(lock), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .core_in_rd(core_in_rd), .core_out_wr(core_out_wr), .core_sts_wr(core_sts_wr),
    .core_f0_we(core_f0_we), .core_f0_val(core_f0_val),
    .core_nib(core_wdata[DW-1:ST_USR]), .status(status)
  );

  hostlink_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst), .core_port_wr(core_port_wr), .core_wdata(core_wdata),
    .core_en_flags(core_en_flags), .core_en_dma(core_en_dma),
    .obf(status[ST_OBF]), .ibf(status[ST_IBF]), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .dma_en(dma_en), .drq(drq), .pin_out(port_hi_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf_q <= '0;
      obuf_q <= '0;
    end else begin
      if (wr_evt.done) ibuf_q <= wr_data;
      if (core_out_wr) obuf_q <= core_wdata;
    end
  end

  assign core_in_data = ibuf_q;
  assign core_flags   = status[3:0];
endmodule

// File: rtl/hostlink_chk.sv
module hostlink_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] status,
  input logic          lock,
  input logic          wr_done,
  input logic          wr_a0,
  input logic          rd_done,
  input logic          rd_a0,
  input logic          core_sts_wr,
  input logic [DW-1:0] core_wdata,
  input logic          core_en_dma,
  input logic          drq,
  input logic          host_rd_n,
  input logic          host_doe
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && !host_doe));
  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !wr_a0) |=> (!status[3] && status[1]));
  // R3
  cmd_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_done && wr_a0) |=> (status[3] && status[1]));
  // R4
  ibf_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> $past(wr_done));
  // R5
  user_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (core_sts_wr && !lock) |=> (status[DW-1:4] == $past(core_wdata[DW-1:4])));
  // R6
  status_lock_chk: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(status));
  // R7
  obf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) |-> $past(rd_done && !rd_a0));
  // R8
  bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
    host_doe |-> $past(!host_rd_n));
  // R10
  drq_reenable_chk: assert property (@(posedge clk) disable iff (rst)
    core_en_dma |=> !drq);
endmodule

bind hostlink_buffer hostlink_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .status(status), .lock(lock),
  .wr_done(wr_evt.done), .wr_a0(wr_evt.a0),
  .rd_done(rd_evt.done), .rd_a0(rd_evt.a0),
  .core_sts_wr(core_sts_wr), .core_wdata(core_wdata),
  .core_en_dma(core_en_dma), .drq(drq),
  .host_rd_n(host_rd_n), .host_doe(host_doe)
);

// File: tb/hostlink_buffer_test.sv
`timescale 1ns/1ps
module hostlink_buffer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;
  logic host_doe;
  logic dack_n = 1'b1;
  logic core_in_rd = 0, core_out_wr = 0, core_sts_wr = 0, core_f0_we = 0, core_f0_val = 0;
  logic core_port_wr = 0, core_en_flags = 0, core_en_dma = 0;
  logic [7:0] core_wdata = '0;
  logic [7:0] core_in_data;
  logic [3:0] core_flags, port_hi_out;

  int checks = 0, failures = 0;

  // model state
  logic m_ibf = 0, m_obf = 0, m_f0 = 0, m_f1 = 0, m_fl = 0, m_dma = 0, m_drq = 0;
  logic [3:0] m_nib = '0, m_latch = 4'hF;
  logic [7:0] m_ibuf = '0, m_obuf = '0;

  always #2 clk = ~clk;

  hostlink_buffer uut (
    .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_a0(host_a0), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .dack_n(dack_n),
    .core_in_rd(core_in_rd), .core_in_data(core_in_data), .core_out_wr(core_out_wr),
    .core_sts_wr(core_sts_wr), .core_f0_we(core_f0_we), .core_f0_val(core_f0_val),
    .core_wdata(core_wdata), .core_port_wr(core_port_wr),
    .core_en_flags(core_en_flags), .core_en_dma(core_en_dma),
    .core_flags(core_flags), .port_hi_out(port_hi_out)
  );

  function automatic logic [7:0] exp_status();
    return {m_nib, m_f1, m_f0, m_ibf, m_obf};
  endfunction

  function automatic logic [3:0] exp_pins();
    logic [3:0] p;
    p[0] = m_latch[0] & (m_fl ? m_obf : 1'b1);
    p[1] = m_latch[1] & (m_fl ? ~m_ibf : 1'b1);
    p[2] = m_dma ? m_drq : m_latch[2];
    p[3] = m_dma ? 1'b1 : m_latch[3];
    return p;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " flags"}, core_flags, exp_status() & 8'h0F);
    check({req, " pins"}, port_hi_out, exp_pins());
    check({req, " inreg"}, core_in_data, m_ibuf);
  endtask

  task automatic host_write(input logic a0v, input logic [7:0] d, input logic use_dack);
    @(negedge clk);
    if (use_dack) dack_n = 1'b0; else host_cs_n = 1'b0;
    host_a0 = a0v; host_din = d; host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1; host_cs_n = 1'b1; dack_n = 1'b1;
    if (!use_dack || m_dma) begin
      m_ibf = 1'b1; m_ibuf = d;
      m_f1 = use_dack ? 1'b0 : a0v;
      if (use_dack) m_drq = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(input logic a0v, input logic use_dack, input string req);
    logic sel, ea0;
    logic [7:0] exp;
    sel = !use_dack || m_dma;
    ea0 = use_dack ? 1'b0 : a0v;
    exp = ea0 ? exp_status() : m_obuf;
    @(negedge clk);
    if (use_dack) dack_n = 1'b0; else host_cs_n = 1'b0;
    host_a0 = a0v; host_rd_n = 1'b0;
    @(negedge clk);
    check({req, " doe"}, host_doe, sel);
    if (sel) check({req, " dout"}, host_dout, exp);
    @(negedge clk);
    host_rd_n = 1'b1; host_cs_n = 1'b1; dack_n = 1'b1;
    if (sel) begin
      if (!ea0) m_obf = 1'b0;
      if (use_dack) m_drq = 1'b0;
    end
    repeat (3) @(negedge clk);
    check({req, " doe off"}, host_doe, 0);
  endtask

  // kinds: 0 in_rd, 1 out_wr, 2 sts_wr, 3 f0, 4 port_wr, 5 en_flags, 6 en_dma
  task automatic core_op(input int kind, input logic [7:0] d);
    @(negedge clk);
    core_wdata = d;
    case (kind)
      0: core_in_rd = 1'b1;
      1: core_out_wr = 1'b1;
      2: core_sts_wr = 1'b1;
      3: begin core_f0_we = 1'b1; core_f0_val = d[0]; end
      4: core_port_wr = 1'b1;
      5: core_en_flags = 1'b1;
      default: core_en_dma = 1'b1;
    endcase
    @(negedge clk);
    core_in_rd = 0; core_out_wr = 0; core_sts_wr = 0; core_f0_we = 0;
    core_port_wr = 0; core_en_flags = 0; core_en_dma = 0;
    case (kind)
      0: m_ibf = 1'b0;
      1: begin m_obuf = d; m_obf = 1'b1; end
      2: m_nib = d[7:4];
      3: m_f0 = d[0];
      4: begin m_latch = d[7:4]; if (m_dma && d[6]) m_drq = 1'b1; end
      5: m_fl = 1'b1;
      default: begin m_dma = 1'b1; m_drq = 1'b0; end
    endcase
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 flags", core_flags, 0);
    check("R1 pins", port_hi_out, 4'hF);
    check("R1 doe", host_doe, 0);
    host_read(1'b1, 1'b0, "R1 status");

    // R2 data write
    host_write(1'b0, 8'h5A, 1'b0);
    check_state("R2");
    // R3 command write
    host_write(1'b1, 8'hC4, 1'b0);
    check_state("R3");
    check("R3 f1", core_flags[3], 1);
    core_op(0, 8'h00);
    check_state("R7 take");

    // R4 flags wait for trailing edge
    @(negedge clk);
    host_cs_n = 0; host_a0 = 1; host_din = 8'h33; host_wr_n = 0;
    repeat (4) @(negedge clk);
    check("R4 ibf held", core_flags[1], 0);
    check("R4 f1 held", core_flags[3], 1);
    host_wr_n = 1; host_cs_n = 1;
    m_ibf = 1; m_f1 = 1; m_ibuf = 8'h33;
    repeat (3) @(negedge clk);
    check_state("R4 after");

    // R5 user nibble
    core_op(2, 8'hC3);
    host_read(1'b1, 1'b0, "R5 status");

    // R7/R8 output register
    core_op(1, 8'h77);
    check_state("R7 obf set");
    host_read(1'b0, 1'b0, "R8 data read");
    check_state("R7 obf clear");

    // R6 lockout
    @(negedge clk);
    host_cs_n = 0; host_a0 = 1; host_rd_n = 0;
    repeat (2) @(negedge clk);
    core_sts_wr = 1; core_in_rd = 1; core_wdata = 8'hA0;
    @(negedge clk);
    core_sts_wr = 0; core_in_rd = 0;
    repeat (2) @(negedge clk);
    check("R6 frozen dout", host_dout, exp_status());
    check("R6 ibf held", core_flags[1], 1);
    host_rd_n = 1; host_cs_n = 1;
    m_nib = 4'hA; m_ibf = 0;
    repeat (3) @(negedge clk);
    check_state("R6 applied");
    host_read(1'b1, 1'b0, "R6 status after");

    // R9 flag pins
    core_op(5, 8'h00);
    check_state("R9 flags on");
    core_op(1, 8'h12);
    check_state("R9 obf pin");
    core_op(4, 8'h00);
    check_state("R9 latch low");
    core_op(4, 8'hF0);

    // R11 acknowledge ignored before DMA mode
    host_read(1'b0, 1'b1, "R11 ignored rd");
    host_write(1'b0, 8'h99, 1'b1);
    check_state("R11 ignored wr");
    // R10/R11 DMA
    core_op(6, 8'h00);
    check_state("R11 dack pin");
    core_op(4, 8'hF0);
    check("R10 drq up", port_hi_out[2], 1);
    host_read(1'b1, 1'b1, "R11 dack forces data");
    check_state("R10 drq cleared");
    core_op(4, 8'h40);
    host_write(1'b1, 8'h6B, 1'b1);
    check_state("R10 drq wr clear");
    core_op(4, 8'hF0);
    core_op(6, 8'h00);
    check_state("R10 reenable clear");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 11));
      d = 8'($urandom);
      case (op)
        0, 1: host_write(d[0], d, 1'b0);
        2:    host_write(1'b0, d, d[1]);
        3:    host_read(d[0], 1'b0, "R8 random read");
        4:    host_read(d[0], 1'b1, "R11 random dack read");
        5:    core_op(0, d);
        6:    core_op(1, d);
        7:    core_op(2, d);
        8:    core_op(3, d);
        9:    core_op(4, d);
        10:   core_op(5, d);
        default: core_op(6, d);
      endcase
      check_state("R7 random");
    end
    host_read(1'b1, 1'b0, "R5 final status");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule